// File: doc/BRIEF.md
# Indexed scan-out with dirty-line coalescing

This block refreshes a display surface from an 8-bit indexed frame buffer. On each pass it walks the lines of the buffer in order and decides, line by line, whether that line has to be redrawn. A line is redrawn when a full-redraw request is pending or when the line has been marked dirty since the previous pass. Each redrawn line is read from an external synchronous pixel memory. Every pixel index is converted through a 256-entry colour palette into a 32-bit packed RGB word.

Runs of consecutive redrawn lines are merged into update records. Each record carries the first line and the number of lines in the run, and it leaves through a valid/ready handshake. The scan pauses while a record is waiting to be accepted. A pass ends with a one-cycle frame-end pulse, which the interrupt logic can use. At that point the full-redraw request that the pass honoured is retired.

Line dirty marks come from a separate write-tracking block through a per-line mark strobe. An invalidate strobe marks every line at once. Marks are captured into a private snapshot at the start of a pass, so a mark that arrives while a pass is running applies to the next pass.

Top module: `lut_scanout`

## Requirements
- R1: Each emitted pixel word is {8'h00, red, green, blue}, where {red, green, blue} is the 24-bit palette entry written at the index equal to the pixel's 8-bit value. The palette stores red in bits 23:16, green in 15:8 and blue in 7:0.
- R2: Pixels of a redrawn line y are read from address y*width+x, with x rising from 0 to width-1. Lines are processed in increasing y.
- R3: A line is redrawn when a full redraw is pending for the pass or when its dirty snapshot bit is set. A line that is not redrawn emits no pixels.
- R4: When a clean line follows a run of redrawn lines, one record is issued with start = the first line of the run and count = the number of lines in the run.
- R5: A run that is still open after the last line is issued at the end of the pass with count = height - start. This record is issued before the frame-end pulse.
- R6: A pending full redraw is retired at the end of the pass that honoured it. A redraw request made while a pass is running stays pending for the following pass.
- R7: Each pass produces exactly one single-cycle frame_done pulse. The pulse comes after all of the pass's pixels and records. busy is high from the cycle after start_pass until frame_done.
- R8: An invalidate strobe makes every line dirty for the next pass.
- R9: A record holds rec_valid, rec_start and rec_count stable until rec_ready is high. While a record is held, no further line is processed.
- R10: The dirty flags are copied and cleared when a pass starts. A mark that arrives after the start applies only to the next pass.
- R11: After reset, busy, rec_valid, px_valid, pix_rd and frame_done are low, and a full redraw is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(MAX_W+1) | Line width in pixels, sampled at pass start |
| cfg_height | input | $clog2(MAX_H+1) | Number of lines, sampled at pass start |
| start_pass | input | 1 | Starts a pass when idle |
| redraw_req | input | 1 | Requests a full redraw |
| invalidate | input | 1 | Marks every line dirty |
| mark_en | input | 1 | Marks line mark_line dirty |
| mark_line | input | $clog2(MAX_H) | Line to mark |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | IDX_W | Palette write index |
| pal_rgb | input | 24 | Palette entry {red, green, blue} |
| pix_rd | output | 1 | Pixel memory read enable |
| pix_addr | output | $clog2(MAX_W*MAX_H) | Pixel memory address |
| pix_data | input | IDX_W | Pixel memory data, one cycle after pix_rd |
| px_valid | output | 1 | Output pixel valid |
| px_rgb | output | 32 | Packed output pixel |
| rec_valid | output | 1 | Update record valid |
| rec_ready | input | 1 | Update record accepted |
| rec_start | output | $clog2(MAX_H+1) | First line of the run |
| rec_count | output | $clog2(MAX_H+1) | Lines in the run |
| frame_done | output | 1 | End-of-pass pulse |
| busy | output | 1 | A pass is in progress |

## Verification
The case that is hardest to reach from the ports is a record held under backpressure while a dirty line waits behind it. In that case the scan must stop between two runs without losing the run that is already open. The bench reaches it by marking two dirty lines with a clean line between them and holding rec_ready low before the pass starts. It then checks that the pixel count stays at one line and that the held record stays unchanged, and only then releases rec_ready. A mark or a redraw request that arrives in the middle of a pass is also hard to place. The bench times the strobe a few cycles after start_pass and then checks both that pass and the next one.

// File: rtl/lut_scan_pkg.sv
package lut_scan_pkg;
  localparam int RGB_W = 24;
  localparam int OUT_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINE,
    ST_PIX,
    ST_FLUSH,
    ST_DRAIN
  } scan_st_t;

  function automatic logic [OUT_W-1:0] pack_rgb(input logic [RGB_W-1:0] c);
    return {8'h00, c};
  endfunction
endpackage

// File: rtl/lut_palette_ram.sv
module lut_palette_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  // simple dual-port RAM, read-first on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lut_line_dirty.sv
module lut_line_dirty #(
  parameter int MAX_H   = 2048,
  parameter int LINE_AW = $clog2(MAX_H)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mark_en,
  input  logic [LINE_AW-1:0] mark_line,
  input  logic               inval_all,
  input  logic               sample,
  input  logic [LINE_AW-1:0] rd_line,
  output logic               rd_dirty
);
  logic [MAX_H-1:0] live_q;
  logic [MAX_H-1:0] snap_q;
  logic [MAX_H-1:0] live_n;

  // marks landing on the sampling cycle belong to the next pass
  always_comb begin
    live_n = sample ? '0 : live_q;
    if (inval_all) live_n = '1;
    if (mark_en) live_n[mark_line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      snap_q <= '0;
    end else begin
      live_q <= live_n;
      if (sample) snap_q <= live_q;
    end
  end

  assign rd_dirty = snap_q[rd_line];

  AST_INVAL_FILLS: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (live_q == '1)); // R8
endmodule

// File: rtl/lut_run_merge.sv
module lut_run_merge #(
  parameter int H_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           step_dirty,
  input  logic [H_W-1:0] step_line,
  input  logic           flush,
  input  logic [H_W-1:0] flush_line,
  input  logic           rec_ready,
  output logic           rec_valid,
  output logic [H_W-1:0] rec_start,
  output logic [H_W-1:0] rec_count
);
  logic           open_q;
  logic [H_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      start_q   <= '0;
      rec_valid <= 1'b0;
      rec_start <= '0;
      rec_count <= '0;
    end else begin
      if (rec_valid && rec_ready) rec_valid <= 1'b0;
      if (step) begin
        if (step_dirty) begin
          if (!open_q) begin
            open_q  <= 1'b1;
            start_q <= step_line;
          end
        end else if (open_q) begin
          open_q    <= 1'b0;
          rec_valid <= 1'b1;
          rec_start <= start_q;
          rec_count <= step_line - start_q;
        end
      end else if (flush && open_q) begin
        open_q    <= 1'b0;
        rec_valid <= 1'b1;
        rec_start <= start_q;
        rec_count <= flush_line - start_q;
      end
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_start) && $stable(rec_count))); // R9
  AST_NO_STEP_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    (step || flush) |-> !rec_valid); // R9
  AST_REC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_count != '0)); // R4
endmodule

// File: rtl/lut_pixel_pipe.sv
module lut_pixel_pipe
  import lut_scan_pkg::*;
#(
  parameter int FB_AW = 22,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [FB_AW-1:0] rd_addr,
  output logic             pix_rd,
  output logic [FB_AW-1:0] pix_addr,
  input  logic [IDX_W-1:0] pix_data,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_idx,
  input  logic [RGB_W-1:0] pal_rgb,
  output logic             px_valid,
  output logic [OUT_W-1:0] px_rgb,
  output logic             empty
);
  logic             data_v;
  logic             lut_v;
  logic [RGB_W-1:0] lut_q;

  lut_palette_ram #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_idx),
    .wdata (pal_rgb),
    .re    (data_v),
    .raddr (pix_data),
    .rdata (lut_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_rd   <= 1'b0;
      pix_addr <= '0;
      data_v   <= 1'b0;
      lut_v    <= 1'b0;
      px_valid <= 1'b0;
      px_rgb   <= '0;
    end else begin
      pix_rd   <= rd_req;
      if (rd_req) pix_addr <= rd_addr;
      data_v   <= pix_rd;
      lut_v    <= data_v;
      px_valid <= lut_v;
      if (lut_v) px_rgb <= pack_rgb(lut_q);
    end
  end

  assign empty = !(pix_rd || data_v || lut_v);
endmodule

// File: rtl/lut_scanout.sv
module lut_scanout
  import lut_scan_pkg::*;
#(
  parameter int MAX_W = 2048,
  parameter int MAX_H = 2048,
  parameter int IDX_W = 8,
  localparam int W_W     = $clog2(MAX_W + 1),
  localparam int H_W     = $clog2(MAX_H + 1),
  localparam int LINE_AW = $clog2(MAX_H),
  localparam int FB_AW   = $clog2(MAX_W * MAX_H)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W_W-1:0]     cfg_width,
  input  logic [H_W-1:0]     cfg_height,
  input  logic               start_pass,
  input  logic               redraw_req,
  input  logic               invalidate,
  input  logic               mark_en,
  input  logic [LINE_AW-1:0] mark_line,
  input  logic               pal_we,
  input  logic [IDX_W-1:0]   pal_idx,
  input  logic [RGB_W-1:0]   pal_rgb,
  output logic               pix_rd,
  output logic [FB_AW-1:0]   pix_addr,
  input  logic [IDX_W-1:0]   pix_data,
  output logic               px_valid,
  output logic [OUT_W-1:0]   px_rgb,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [H_W-1:0]     rec_start,
  output logic [H_W-1:0]     rec_count,
  output logic               frame_done,
  output logic               busy
);
  scan_st_t         st_q;
  logic [H_W-1:0]   y_q, height_q;
  logic [W_W-1:0]   x_q, width_q;
  logic [FB_AW-1:0] base_q;
  logic             pass_full_q, full_pend_q, req_mid_q;

  logic             snap_dirty, line_dirty, sample, step, flush;
  logic             rd_req, pipe_empty;
  logic [FB_AW-1:0] rd_addr;

  assign sample     = (st_q == ST_IDLE) && start_pass;
  assign line_dirty = pass_full_q || snap_dirty;
  assign step       = (st_q == ST_LINE) && !rec_valid && (y_q != height_q);
  assign flush      = (st_q == ST_FLUSH) && !rec_valid;
  assign rd_req     = (st_q == ST_PIX);
  assign rd_addr    = base_q + FB_AW'(x_q);
  assign busy       = (st_q != ST_IDLE);

  lut_line_dirty #(.MAX_H(MAX_H), .LINE_AW(LINE_AW)) u_dirty (
    .clk       (clk),
    .rst       (rst),
    .mark_en   (mark_en),
    .mark_line (mark_line),
    .inval_all (invalidate),
    .sample    (sample),
    .rd_line   (y_q[LINE_AW-1:0]),
    .rd_dirty  (snap_dirty)
  );

  lut_run_merge #(.H_W(H_W)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .step_dirty (line_dirty),
    .step_line  (y_q),
    .flush      (flush),
    .flush_line (height_q),
    .rec_ready  (rec_ready),
    .rec_valid  (rec_valid),
    .rec_start  (rec_start),
    .rec_count  (rec_count)
  );

  lut_pixel_pipe #(.FB_AW(FB_AW), .IDX_W(IDX_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .pix_rd   (pix_rd),
    .pix_addr (pix_addr),
    .pix_data (pix_data),
    .pal_we   (pal_we),
    .pal_idx  (pal_idx),
    .pal_rgb  (pal_rgb),
    .px_valid (px_valid),
    .px_rgb   (px_rgb),
    .empty    (pipe_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      y_q         <= '0;
      x_q         <= '0;
      base_q      <= '0;
      width_q     <= '0;
      height_q    <= '0;
      pass_full_q <= 1'b0;
      full_pend_q <= 1'b1;
      req_mid_q   <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (busy && redraw_req) req_mid_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (redraw_req) full_pend_q <= 1'b1;
          if (start_pass) begin
            pass_full_q <= full_pend_q || redraw_req;
            width_q     <= cfg_width;
            height_q    <= cfg_height;
            y_q         <= '0;
            x_q         <= '0;
            base_q      <= '0;
            req_mid_q   <= 1'b0;
            st_q        <= ST_LINE;
          end
        end
        ST_LINE: begin
          if (y_q == height_q) begin
            st_q <= ST_FLUSH;
          end else if (!rec_valid) begin
            if (line_dirty && (width_q != '0)) begin
              x_q  <= '0;
              st_q <= ST_PIX;
            end else begin
              y_q    <= y_q + 1'b1;
              base_q <= base_q + FB_AW'(width_q);
            end
          end
        end
        ST_PIX: begin
          if (x_q == width_q - 1'b1) begin
            y_q    <= y_q + 1'b1;
            base_q <= base_q + FB_AW'(width_q);
            st_q   <= ST_LINE;
          end else begin
            x_q <= x_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (!rec_valid) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!rec_valid && pipe_empty) begin
            st_q        <= ST_IDLE;
            frame_done  <= 1'b1;
            full_pend_q <= req_mid_q || redraw_req;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R7
  AST_DONE_NO_REC: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !rec_valid); // R5
  AST_PX_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> busy); // R7
  AST_READ_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (x_q < width_q)); // R2
  AST_CLEAN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (step && !line_dirty) |=> (st_q != ST_PIX)); // R3
endmodule

// File: tb/lut_scanout_bench.sv
module lut_scanout_bench;
  localparam int MW = 64;
  localparam int MH = 64;
  localparam int W_W = $clog2(MW + 1);
  localparam int H_W = $clog2(MH + 1);
  localparam int LA  = $clog2(MH);
  localparam int FA  = $clog2(MW * MH);

  // scenario: [39:32] width, [31:24] height, [23:8] dirty line mask, [0] full redraw
  localparam int NSC = 6;
  localparam logic [39:0] SCEN [0:NSC-1] = '{
    {8'd4, 8'd6,  16'h000D, 8'd0},
    {8'd3, 8'd5,  16'h0018, 8'd0},
    {8'd5, 8'd4,  16'h0000, 8'd1},
    {8'd2, 8'd8,  16'h00AA, 8'd0},
    {8'd6, 8'd3,  16'h0000, 8'd0},
    {8'd1, 8'd16, 16'hFFFF, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W_W-1:0] cfg_width = '0;
  logic [H_W-1:0] cfg_height = '0;
  logic start_pass = 0, redraw_req = 0, invalidate = 0, mark_en = 0;
  logic [LA-1:0] mark_line = '0;
  logic pal_we = 0;
  logic [7:0] pal_idx = '0;
  logic [23:0] pal_rgb = '0;
  logic pix_rd;
  logic [FA-1:0] pix_addr;
  logic [7:0] pix_data = '0;
  logic px_valid;
  logic [31:0] px_rgb;
  logic rec_valid;
  logic rec_ready = 1'b1;
  logic [H_W-1:0] rec_start, rec_count;
  logic frame_done, busy;

  always #10 clk = ~clk;

  lut_scanout #(.MAX_W(MW), .MAX_H(MH), .IDX_W(8)) u_lut_scanout (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .start_pass(start_pass), .redraw_req(redraw_req), .invalidate(invalidate),
    .mark_en(mark_en), .mark_line(mark_line), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_rgb(pal_rgb), .pix_rd(pix_rd), .pix_addr(pix_addr), .pix_data(pix_data),
    .px_valid(px_valid), .px_rgb(px_rgb), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_start(rec_start), .rec_count(rec_count), .frame_done(frame_done), .busy(busy)
  );

  function automatic logic [7:0] fb_val(input int a);
    return 8'((a * 13) + 7);
  endfunction

  function automatic logic [23:0] pal_val(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b, b ^ 8'hA5, ~b};
  endfunction

  always @(posedge clk) if (pix_rd) pix_data <= fb_val(int'(pix_addr));

  int total = 0, fails = 0;
  logic [31:0] exp_px [0:1023];
  int exp_rs [0:63];
  int exp_rc [0:63];
  int got_rs [0:63];
  int got_rc [0:63];
  int exp_pn, exp_rn;
  int px_n, px_bad, rec_n, done_n;
  logic [31:0] bad_act, bad_exp;
  logic mon_clr = 1'b0;
  bit finished = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      px_n = 0; px_bad = 0; rec_n = 0; done_n = 0;
    end else begin
      if (px_valid) begin
        if (px_n < 1024 && px_rgb !== exp_px[px_n]) begin
          if (px_bad == 0) begin bad_act = px_rgb; bad_exp = exp_px[px_n]; end
          px_bad++;
        end
        px_n++;
      end
      if (rec_valid && rec_ready) begin
        if (rec_n < 64) begin got_rs[rec_n] = int'(rec_start); got_rc[rec_n] = int'(rec_count); end
        rec_n++;
      end
      if (frame_done) done_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic build_expect(input int w, input int h, input logic [63:0] mask, input bit full);
    int run_s;
    exp_pn = 0; exp_rn = 0; run_s = -1;
    for (int y = 0; y < h; y++) begin
      if (full || mask[y]) begin
        if (run_s < 0) run_s = y;
        for (int x = 0; x < w; x++) begin
          exp_px[exp_pn] = {8'h00, pal_val(int'(fb_val(y * w + x)))};
          exp_pn++;
        end
      end else if (run_s >= 0) begin
        exp_rs[exp_rn] = run_s; exp_rc[exp_rn] = y - run_s; exp_rn++; run_s = -1;
      end
    end
    if (run_s >= 0) begin
      exp_rs[exp_rn] = run_s; exp_rc[exp_rn] = h - run_s; exp_rn++;
    end
  endtask

  task automatic mark_lines(input logic [63:0] mask, input int h);
    for (int y = 0; y < h; y++) begin
      if (mask[y]) begin
        mark_en = 1'b1; mark_line = LA'(y); tick(); mark_en = 1'b0;
      end
    end
  endtask

  task automatic begin_pass(input int w, input int h, input int mid_mark, input bit mid_redraw);
    mon_clr = 1'b1; tick(); mon_clr = 1'b0;
    cfg_width = W_W'(w); cfg_height = H_W'(h);
    start_pass = 1'b1; tick(); start_pass = 1'b0;
    tick();
    if (mid_mark >= 0) begin mark_en = 1'b1; mark_line = LA'(mid_mark); tick(); mark_en = 1'b0; end
    if (mid_redraw) begin redraw_req = 1'b1; tick(); redraw_req = 1'b0; end
  endtask

  task automatic finish_pass();
    while (done_n == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pass(input string rtag);
    chk(done_n == 1, "R7", "frame_done pulses", done_n, 1);
    chk(px_n == exp_pn, "R3", "pixel count", px_n, exp_pn);
    chk(px_bad == 0, "R1 R2", "pixel word", int'(bad_act), int'(bad_exp));
    chk(rec_n == exp_rn, rtag, "record count", rec_n, exp_rn);
    for (int k = 0; k < exp_rn && k < rec_n; k++) begin
      chk(got_rs[k] == exp_rs[k], rtag, "record start", got_rs[k], exp_rs[k]);
      chk(got_rc[k] == exp_rc[k], rtag, "record count field", got_rc[k], exp_rc[k]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !rec_valid && !px_valid && !pix_rd && !frame_done, "R11", "outputs idle after reset",
        int'({busy, rec_valid, px_valid, pix_rd, frame_done}), 0);
    tick();
    for (int i = 0; i < 256; i++) begin
      pal_we = 1'b1; pal_idx = 8'(i); pal_rgb = pal_val(i); tick();
    end
    pal_we = 1'b0;

    // R11: full redraw pending out of reset, no marks given
    build_expect(2, 3, 64'h0, 1'b1);
    begin_pass(2, 3, -1, 1'b0); finish_pass(); check_pass("R11");

    // table-driven passes (R4, R5, R3, R6 via the pass after the full one)
    for (int s = 0; s < NSC; s++) begin
      int w, h; logic [63:0] m; bit f;
      w = int'(SCEN[s][39:32]); h = int'(SCEN[s][31:24]);
      m = 64'(SCEN[s][23:8]); f = SCEN[s][0];
      mark_lines(m, h);
      if (f) begin redraw_req = 1'b1; tick(); redraw_req = 1'b0; end
      build_expect(w, h, m, f);
      begin_pass(w, h, -1, 1'b0); finish_pass(); check_pass("R4 R5");
    end

    // R9 backpressure: lines 0 and 2 dirty, record held while line 2 waits
    mark_lines(64'h5, 4);
    build_expect(3, 4, 64'h5, 1'b0);
    rec_ready = 1'b0;
    begin_pass(3, 4, -1, 1'b0);
    repeat (40) @(negedge clk);
    chk(px_n == 3, "R9", "pixels while record held", px_n, 3);
    chk(rec_valid && rec_start == 0 && rec_count == 1, "R9", "held record",
        int'(rec_count), 1);
    repeat (10) @(negedge clk);
    chk(px_n == 3 && rec_valid && rec_count == 1, "R9", "scan still stalled", px_n, 3);
    tick(); rec_ready = 1'b1;
    finish_pass(); check_pass("R9");

    // R8 invalidate marks every line
    invalidate = 1'b1; tick(); invalidate = 1'b0;
    build_expect(3, 5, 64'h1F, 1'b0);
    begin_pass(3, 5, -1, 1'b0); finish_pass(); check_pass("R8");

    // R10 mark during a pass lands in the next pass
    build_expect(4, 4, 64'h0, 1'b0);
    begin_pass(4, 4, 2, 1'b0); finish_pass(); check_pass("R10");
    build_expect(4, 4, 64'h4, 1'b0);
    begin_pass(4, 4, -1, 1'b0); finish_pass(); check_pass("R10");

    // R6 redraw request during a pass stays pending, then retires
    build_expect(2, 4, 64'h0, 1'b0);
    begin_pass(2, 4, -1, 1'b1); finish_pass(); check_pass("R6");
    build_expect(2, 4, 64'h0, 1'b1);
    begin_pass(2, 4, -1, 1'b0); finish_pass(); check_pass("R6");
    build_expect(2, 4, 64'h0, 1'b0);
    begin_pass(2, 4, -1, 1'b0); finish_pass(); check_pass("R6");
    chk(!busy, "R7", "busy low after pass", int'(busy), 0);

    finished = 1;
    summary();
  end
endmodule